// File: doc/BRIEF.md
# Partial Reconfiguration Handshake Sequencer

This block drives the handshake that reloads one region of a device while the rest of it keeps running. Once a host issues a start command, the sequencer does several things in turn. It takes over the configuration inputs and raises a reconfiguration request. It then clocks the configuration controller with short bursts of a gated configuration clock until the controller reports that it is ready. After that, it streams 16-bit image words from a ready/valid source into the controller.

When the controller's status lines signal success or failure, the sequencer first closes the data path and then drops the request. It sends a long closing clock burst and waits for every status line to return low. Only then does it hand the configuration inputs back to the external pins.

The clock-burst engine is a down-counter that is loaded with a fixed length for each phase. The long closing burst also sets a sticky completion flag, which the host clears by writing a 1 to it. The outcome of each run is reported on the done and error outputs, together with a three-bit cause code.

Top module: `pr_handshake_seq`

## Requirements
- R1: A start pulse received while idle is accepted only if `user_mode_i` is high. Otherwise, in the next cycle, `error_o` is 1, `err_cause_o` is 1 (rejected), and `busy_o` and `own_en_o` stay 0. An accepted start clears `error_o` and `done_o`.
- R2: `own_en_o` rises one cycle before `pr_request_o` rises. It falls only when the block returns to idle.
- R3: `ratio_o` takes the value of `ratio_i` at the accepted start. It holds that value while the sequence runs, whatever `ratio_i` does afterwards.
- R4: While the request is high and ready has not been seen, the block sends one clock pulse and then samples `pr_ready_i` on the first cycle after the pulse with no clock. If ready is low, it repeats the pulse and sample. After `POLL_MAX` (16) pulses without ready, it stops waiting with cause 4 (ready timeout), drops the request and runs the closing burst.
- R5: After ready is seen, exactly 3 clock pulses are sent before `img_ready_o` rises.
- R6: While `img_ready_o` is high, `dclk_o` equals `img_valid_i`. `cfg_data_o` carries `img_data_i` on accepted cycles and is 0 otherwise.
- R7: During transfer, completion is PR done with both errors low (success, cause 0), or PR error (cause 2), or CRC error (cause 3). If both errors are high, PR error takes priority. On completion, `img_ready_o` drops one cycle before `pr_request_o` drops.
- R8: After the request drops, exactly 128 clock pulses are sent. `burst_done_o` rises in the first cycle after the last pulse.
- R9: `burst_done_o` stays 1 until a cycle with `burst_clr_i` high, and is 0 from the next cycle on.
- R10: The block stays busy after the closing burst until PR done, PR ready, PR error and CRC error are all low. It then goes idle with `done_o` equal to 1 for cause 0 or `error_o` equal to 1 for any other cause.
- R11: Reset in the middle of a sequence returns all outputs to their idle values, with `done_o` 0. A new start then runs the full sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command pulse |
| user_mode_i | input | 1 | Device is in user mode |
| ratio_i | input | RATIO_W | Clock-to-data ratio for the image |
| img_data_i | input | DATA_W | Image word |
| img_valid_i | input | 1 | Image word valid |
| img_ready_o | output | 1 | Image word accepted when valid |
| pr_ready_i | input | 1 | Controller ready status |
| pr_done_i | input | 1 | Controller done status |
| pr_error_i | input | 1 | Controller reconfiguration error |
| crc_error_i | input | 1 | Controller CRC error |
| burst_clr_i | input | 1 | Write-one-to-clear for burst flag |
| own_en_o | output | 1 | Block owns the configuration inputs |
| pr_request_o | output | 1 | Reconfiguration request |
| dclk_o | output | 1 | Gated configuration clock enable pulse |
| cfg_data_o | output | DATA_W | Configuration data to controller |
| ratio_o | output | RATIO_W | Latched clock-to-data ratio |
| burst_done_o | output | 1 | Sticky closing-burst complete flag |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence succeeded |
| error_o | output | 1 | Last sequence or start failed |
| err_cause_o | output | 3 | Cause: 0 none, 1 rejected, 2 PR error, 3 CRC error, 4 ready timeout |

## Verification
The assertions take several things for granted about the inputs. The controller status lines change only as a controller would drive them: ready rises during polling, done or an error appears only while words are flowing, and all of them fall in the end. They also assume that `burst_clr_i` is not pulsed in the same cycle as the last closing pulse.

The stimulus keeps within these limits because it behaves as a reactive controller. It counts the `dclk_o` pulses it sees and raises ready after a chosen count. It raises completion status only after a chosen number of accepted words, and it drops every status line only after it has read and cleared the burst flag. It sweeps the ready delay across the whole polling window, then covers each failure kind, the timeout, a rejected start and a reset in mid-run.

// File: rtl/pr_seq_pkg.sv
package pr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OWN,
        ST_POLL,
        ST_RBURST,
        ST_XFER,
        ST_DROP,
        ST_TAIL,
        ST_DRAIN
    } pr_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_REJECT  = 3'd1,
        CAUSE_PRERR   = 3'd2,
        CAUSE_CRCERR  = 3'd3,
        CAUSE_TIMEOUT = 3'd4
    } pr_cause_e;

endpackage

// File: rtl/pr_status_eval.sv
module pr_status_eval
    import pr_seq_pkg::*;
(
    input  logic      pr_done_i,
    input  logic      pr_ready_i,
    input  logic      pr_error_i,
    input  logic      crc_error_i,
    output logic      complete_o,
    output pr_cause_e cause_o,
    output logic      quiet_o
);

    logic [3:0] lines;
    logic       any_err;

    always_comb begin
        lines   = {pr_done_i, pr_ready_i, pr_error_i, crc_error_i};
        any_err = pr_error_i | crc_error_i;
        // error priority: PR error outranks CRC error
        if (pr_error_i) begin
            cause_o = CAUSE_PRERR;
        end else if (crc_error_i) begin
            cause_o = CAUSE_CRCERR;
        end else begin
            cause_o = CAUSE_NONE;
        end
        complete_o = any_err | pr_done_i;
        quiet_o    = (lines == 4'b0000);
    end

endmodule

// File: rtl/pr_dclk_burst.sv
module pr_dclk_burst #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             mark_i,
    input  logic             clr_i,
    output logic             active_o,
    output logic             flag_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mark;
        logic             flag;
    } burst_t;

    burst_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load_i) begin
            nxt_d.cnt  = len_i;
            nxt_d.mark = mark_i;
        end else if (cur_q.cnt != '0) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
        if (clr_i) begin
            nxt_d.flag = 1'b0;
        end
        if (cur_q.mark && (cur_q.cnt == CNT_W'(1))) begin
            nxt_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign active_o = (cur_q.cnt != '0);
    assign flag_o   = cur_q.flag;

    // R8
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !active_o);

    // R8
    flag_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> ($past(active_o) && !active_o));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/pr_handshake_seq.sv
module pr_handshake_seq
    import pr_seq_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int RATIO_W      = 2,
    parameter int POLL_MAX     = 16,
    parameter int READY_PULSES = 3,
    parameter int TAIL_PULSES  = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               user_mode_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [DATA_W-1:0]  img_data_i,
    input  logic               img_valid_i,
    output logic               img_ready_o,
    input  logic               pr_ready_i,
    input  logic               pr_done_i,
    input  logic               pr_error_i,
    input  logic               crc_error_i,
    input  logic               burst_clr_i,
    output logic               own_en_o,
    output logic               pr_request_o,
    output logic               dclk_o,
    output logic [DATA_W-1:0]  cfg_data_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               burst_done_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               error_o,
    output logic [2:0]         err_cause_o
);

    localparam int BURST_MAX = (TAIL_PULSES > READY_PULSES) ? TAIL_PULSES : READY_PULSES;
    localparam int CNT_W     = $clog2(BURST_MAX + 1);
    localparam int POLL_W    = $clog2(POLL_MAX + 1);

    typedef struct packed {
        pr_state_e          state;
        logic [POLL_W-1:0]  polls;
        logic [RATIO_W-1:0] ratio;
        pr_cause_e          cause;
        logic               done;
        logic               error;
    } seq_t;

    seq_t seq_q, seq_d;

    logic             burst_load;
    logic [CNT_W-1:0] burst_len;
    logic             burst_mark;
    logic             burst_active;
    logic             st_complete;
    logic             st_quiet;
    pr_cause_e        st_cause;
    logic             xfer;
    logic             accept;

    pr_status_eval u_status (
        .pr_done_i   (pr_done_i),
        .pr_ready_i  (pr_ready_i),
        .pr_error_i  (pr_error_i),
        .crc_error_i (crc_error_i),
        .complete_o  (st_complete),
        .cause_o     (st_cause),
        .quiet_o     (st_quiet)
    );

    pr_dclk_burst #(.CNT_W(CNT_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (burst_load),
        .len_i    (burst_len),
        .mark_i   (burst_mark),
        .clr_i    (burst_clr_i),
        .active_o (burst_active),
        .flag_o   (burst_done_o)
    );

    always_comb begin
        seq_d      = seq_q;
        burst_load = 1'b0;
        burst_len  = '0;
        burst_mark = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.done = 1'b0;
                    if (user_mode_i) begin
                        seq_d.state = ST_OWN;
                        seq_d.ratio = ratio_i;
                        seq_d.cause = CAUSE_NONE;
                        seq_d.error = 1'b0;
                        seq_d.polls = '0;
                    end else begin
                        seq_d.cause = CAUSE_REJECT;
                        seq_d.error = 1'b1;
                    end
                end
            end
            ST_OWN: begin
                burst_load  = 1'b1;
                burst_len   = CNT_W'(1);
                seq_d.state = ST_POLL;
            end
            ST_POLL: begin
                if (!burst_active) begin
                    if (pr_ready_i) begin
                        burst_load  = 1'b1;
                        burst_len   = CNT_W'(READY_PULSES);
                        seq_d.state = ST_RBURST;
                    end else if (seq_q.polls == POLL_W'(POLL_MAX - 1)) begin
                        seq_d.cause = CAUSE_TIMEOUT;
                        seq_d.state = ST_DROP;
                    end else begin
                        seq_d.polls = seq_q.polls + 1'b1;
                        burst_load  = 1'b1;
                        burst_len   = CNT_W'(1);
                    end
                end
            end
            ST_RBURST: begin
                if (!burst_active) begin
                    seq_d.state = ST_XFER;
                end
            end
            ST_XFER: begin
                if (st_complete) begin
                    seq_d.cause = st_cause;
                    seq_d.state = ST_DROP;
                end
            end
            ST_DROP: begin
                burst_load  = 1'b1;
                burst_len   = CNT_W'(TAIL_PULSES);
                burst_mark  = 1'b1;
                seq_d.state = ST_TAIL;
            end
            ST_TAIL: begin
                if (!burst_active) begin
                    seq_d.state = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (st_quiet) begin
                    seq_d.state = ST_IDLE;
                    seq_d.done  = (seq_q.cause == CAUSE_NONE);
                    seq_d.error = (seq_q.cause != CAUSE_NONE);
                end
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, polls: '0, ratio: '0,
                       cause: CAUSE_NONE, done: 1'b0, error: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        xfer         = (seq_q.state == ST_XFER);
        accept       = xfer & img_valid_i;
        own_en_o     = (seq_q.state != ST_IDLE);
        busy_o       = own_en_o;
        pr_request_o = (seq_q.state == ST_POLL) || (seq_q.state == ST_RBURST) ||
                       (seq_q.state == ST_XFER) || (seq_q.state == ST_DROP);
        img_ready_o  = xfer;
        dclk_o       = burst_active | accept;
        cfg_data_o   = accept ? img_data_i : '0;
        ratio_o      = seq_q.ratio;
        done_o       = seq_q.done;
        error_o      = seq_q.error;
        err_cause_o  = seq_q.cause;
    end

    // R2
    own_before_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pr_request_o) |-> $past(own_en_o));

    // R2
    dclk_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_o |-> own_en_o);

    // R6
    data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready_o |-> pr_request_o);

    // R8
    tail_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pr_request_o) && own_en_o) |-> dclk_o);

    // R10
    quiet_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own_en_o) |-> $past(st_quiet));

    // R1
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !user_mode_i) |=> (error_o && !own_en_o));

endmodule

// File: tb/sim_pr_handshake_seq.sv
module sim_pr_handshake_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        user_mode_i = 1'b0;
    logic [1:0]  ratio_i = '0;
    logic [15:0] img_data_i = '0;
    logic        img_valid_i = 1'b0;
    logic        img_ready_o;
    logic        pr_ready_i = 1'b0;
    logic        pr_done_i = 1'b0;
    logic        pr_error_i = 1'b0;
    logic        crc_error_i = 1'b0;
    logic        burst_clr_i = 1'b0;
    logic        own_en_o;
    logic        pr_request_o;
    logic        dclk_o;
    logic [15:0] cfg_data_o;
    logic [1:0]  ratio_o;
    logic        burst_done_o;
    logic        busy_o;
    logic        done_o;
    logic        error_o;
    logic [2:0]  err_cause_o;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    pr_handshake_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .user_mode_i(user_mode_i),
        .ratio_i(ratio_i), .img_data_i(img_data_i), .img_valid_i(img_valid_i),
        .img_ready_o(img_ready_o), .pr_ready_i(pr_ready_i), .pr_done_i(pr_done_i),
        .pr_error_i(pr_error_i), .crc_error_i(crc_error_i), .burst_clr_i(burst_clr_i),
        .own_en_o(own_en_o), .pr_request_o(pr_request_o), .dclk_o(dclk_o),
        .cfg_data_o(cfg_data_o), .ratio_o(ratio_o), .burst_done_o(burst_done_o),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .err_cause_o(err_cause_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 0 success, 1 PR error, 2 CRC error, 3 both errors, 4 never ready
    task automatic run_seq(input int k, input int nw, input int kind);
        int  poll_p = 0;
        int  post_p = 0;
        int  words = 0;
        int  tail_p = 0;
        bit  xfer_seen = 0;
        bit  flag_seen = 0;
        bit  prev_req = 0;
        bit  prev_rdy = 0;
        int  exp_cause;
        int  exp_poll;
        logic [1:0] r = 2'(k);
        exp_cause = (kind == 0) ? 0 : (kind == 1) ? 2 : (kind == 2) ? 3 : (kind == 3) ? 2 : 4;
        exp_poll  = (kind == 4) ? 16 : k;
        @(negedge clk);
        user_mode_i = 1'b1;
        ratio_i = r;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ratio_i = ~r;
        // R2 ownership precedes request; R1 accepted start clears error
        chk(own_en_o && !pr_request_o, "R2 own before request", {own_en_o, pr_request_o}, 2);
        chk(!error_o && !done_o, "R1 accept clears status", {error_o, done_o}, 0);
        for (int cyc = 0; cyc < 2000 && !flag_seen; cyc++) begin
            @(negedge clk);
            if (pr_request_o && pr_ready_i && !img_ready_o && !xfer_seen && dclk_o) post_p++;
            if (pr_request_o && !pr_ready_i && dclk_o) poll_p++;
            if (kind != 4 && !pr_ready_i && poll_p >= k) pr_ready_i = 1'b1;
            if (img_ready_o) begin
                if (!xfer_seen) begin
                    xfer_seen = 1;
                    chk(poll_p == exp_poll, "R4 poll pulses", poll_p, exp_poll);
                    chk(post_p == 3, "R5 pulses after ready", post_p, 3);
                    chk(ratio_o == r, "R3 ratio held", ratio_o, r);
                end
                chk(dclk_o == img_valid_i, "R6 dclk follows valid", dclk_o, img_valid_i);
                chk(cfg_data_o == (img_valid_i ? img_data_i : 16'h0), "R6 data path",
                    cfg_data_o, img_valid_i ? img_data_i : 0);
                if (img_valid_i) begin
                    words++;
                    img_valid_i = 1'b0;
                    if (words == nw) begin
                        case (kind)
                            0: pr_done_i = 1'b1;
                            1: pr_error_i = 1'b1;
                            2: crc_error_i = 1'b1;
                            default: begin pr_error_i = 1'b1; crc_error_i = 1'b1; end
                        endcase
                    end
                end else if (words < nw) begin
                    img_valid_i = 1'b1;
                    img_data_i = 16'hA500 ^ 16'(words * 37) ^ 16'(k);
                end
            end
            if (prev_req && !pr_request_o) begin
                chk(!prev_rdy, "R7 data closed before request drop", prev_rdy, 0);
                if (kind == 4) chk(poll_p == 16, "R4 timeout pulses", poll_p, 16);
            end
            if (!pr_request_o && own_en_o && dclk_o) tail_p++;
            if (burst_done_o) begin
                flag_seen = 1;
                chk(tail_p == 128, "R8 closing burst length", tail_p, 128);
                chk(!dclk_o, "R8 flag after last pulse", dclk_o, 0);
            end
            prev_req = pr_request_o;
            prev_rdy = img_ready_o;
        end
        chk(flag_seen, "R8 burst flag seen", flag_seen, 1);
        if (kind == 4) chk(!xfer_seen, "R4 no transfer on timeout", xfer_seen, 0);
        else chk(words == nw, "R6 words accepted", words, nw);
        repeat (4) @(negedge clk);
        if (kind != 4) chk(busy_o && own_en_o, "R10 held until quiet", busy_o, 1);
        chk(burst_done_o, "R9 flag sticky", burst_done_o, 1);
        burst_clr_i = 1'b1;
        @(negedge clk);
        burst_clr_i = 1'b0;
        chk(!burst_done_o, "R9 flag cleared", burst_done_o, 0);
        pr_ready_i = 1'b0;
        pr_done_i = 1'b0;
        pr_error_i = 1'b0;
        crc_error_i = 1'b0;
        for (int w = 0; w < 10 && own_en_o; w++) @(negedge clk);
        chk(!own_en_o && !busy_o, "R10 idle after quiet", own_en_o, 0);
        chk(done_o == (exp_cause == 0), "R10 done flag", done_o, exp_cause == 0);
        chk(error_o == (exp_cause != 0), "R10 error flag", error_o, exp_cause != 0);
        chk(err_cause_o == 3'(exp_cause), "R7 cause code", err_cause_o, exp_cause);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!own_en_o && !pr_request_o && !dclk_o && !busy_o && !done_o && !error_o,
            "R11 reset state", {own_en_o, pr_request_o, dclk_o, busy_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 rejected start
        user_mode_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(error_o && err_cause_o == 3'd1, "R1 reject cause", err_cause_o, 1);
        chk(!busy_o && !own_en_o, "R1 reject stays idle", busy_o, 0);
        repeat (2) @(negedge clk);
        chk(!busy_o, "R1 no late start", busy_o, 0);

        // sweep ready delay across the full poll window
        for (int k = 1; k <= 16; k++) run_seq(k, (k % 4) + 1, 0);
        run_seq(3, 2, 1);
        run_seq(5, 3, 2);
        run_seq(2, 1, 3);
        run_seq(0, 0, 4);

        // R11 reset in mid-sequence
        @(negedge clk);
        user_mode_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        chk(pr_request_o, "R11 running before reset", pr_request_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!own_en_o && !pr_request_o && !dclk_o && !busy_o && !done_o,
            "R11 abort outputs", {own_en_o, pr_request_o, dclk_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        pr_ready_i = 1'b0;
        run_seq(4, 2, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule